// File: doc/BRIEF.md
# Speculative Pilot Store Prefill Controller

This controller steers the writes of scattered-pilot sets into a channel-estimation pilot store while the scattered-pilot distribution of the incoming symbols is still being decided. A detector upstream produces two decisions, one after the other. The controller does not wait for both of them. During the first symbol it stores the pilot sets of every candidate distribution. From then on it stores only the set that the first decision predicts for each later symbol. When the second decision agrees with the prediction, channel estimation can begin without waiting for the store to refill.

Each symbol strobe starts the write commands for that symbol. In the first symbol these are one write per candidate distribution, issued on consecutive cycles, and slot k always holds distribution k. After the first decision the prediction becomes the next distribution in the cycle, and each later symbol writes one predicted set into the next free slot. The second decision is judged against the distribution of the most recent predicted write. A match lets the store fill to the end and then raises a start pulse. A mismatch raises a retry pulse, returns the slot pointer to zero and begins the whole procedure again.

Top module: `pfc_top`

## Requirements
- R1: A symbol strobe while the controller waits for a first symbol produces NUM_MODES writes on consecutive cycles, starting the cycle after the strobe. The write of index k uses slot k and distribution code k (0 to 3 by default).
- R2: The first decision is accepted only after the candidate writes are complete and before any prediction exists; a decision during the candidate writes is ignored. The prediction becomes (decision + 1) mod NUM_MODES, and the next symbol strobe writes slot NUM_MODES with that code.
- R3: Each later symbol strobe writes exactly one slot, at the index one above the previous write, the cycle after the strobe. Its distribution code is one above the previous predicted code, mod NUM_MODES.
- R4: Once all NUM_SLOTS slots hold data and no confirmation has arrived, further symbol strobes produce no write.
- R5: A second decision is considered only when at least one predicted write exists. It is then compared with the code of the most recent predicted write. Before that point it causes no write, retry or start.
- R6: On a match, the following symbol strobes fill the remaining slots. The start output pulses for one cycle together with the write of the last slot. If the store is already full, it pulses the cycle after the decision.
- R7: On a mismatch, the retry output pulses for one cycle, the cycle after the decision, and the slot pointer returns to zero. The controller then waits for a new first symbol and a new first decision.
- R8: When a second decision and a symbol strobe arrive in the same cycle, the decision is judged against the writes made before that cycle. On a match the strobe's symbol is written as a fill write. On a mismatch the strobe starts the candidate writes at slot 0, in the same cycle as the retry pulse.
- R9: After the start pulse, all inputs are ignored until reset: there are no further writes, retries or starts.
- R10: During and directly after reset, the write enable, retry and start outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_stb | input | 1 | Pilot set of a new symbol is available |
| det1_vld | input | 1 | First-stage decision strobe |
| det1_mode | input | MODE_W | First-stage distribution code |
| det2_vld | input | 1 | Second-stage decision strobe |
| det2_mode | input | MODE_W | Second-stage distribution code |
| wr_en | output | 1 | Store write command |
| wr_slot | output | SLOT_W | Slot index for the write |
| wr_mode | output | MODE_W | Distribution code whose pilots are written |
| retry | output | 1 | One-cycle pulse: prediction rejected, restart |
| ce_start | output | 1 | One-cycle pulse: channel estimation may begin |

## Verification
The hard case is a second decision and a symbol strobe in the same cycle. In that cycle the verdict on the stored prediction and the handling of the new symbol both resolve. The bench drives both strobes in the same cycle, once with a matching code and once with a mismatching one. On a match it expects a fill write of the next predicted code together with the start pulse. On a mismatch it expects a write of slot 0 with code 0 in the same cycle as the retry pulse. A sweep over every first decision, every second decision and one to three predicted symbols then checks the full sequence of slots and codes, and the cycles of retry and start, against values computed in the bench.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    typedef enum logic [2:0] {
        ST_SYM1  = 3'd0,
        ST_BURST = 3'd1,
        ST_WAIT1 = 3'd2,
        ST_PRED  = 3'd3,
        ST_FILL  = 3'd4,
        ST_DONE  = 3'd5
    } pfc_state_e;
endpackage

// File: rtl/pfc_slot_ptr.sv
module pfc_slot_ptr #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [SLOT_W-1:0] ptr,
    output logic              full
);
    localparam logic [SLOT_W-1:0] FULL_AT = SLOT_W'(NUM_SLOTS);

    logic [SLOT_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = (clr ? '0 : ptr_q) + SLOT_W'(inc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr  = ptr_q;
    assign full = (ptr_q == FULL_AT);
endmodule

// File: rtl/pfc_predictor.sv
module pfc_predictor #(
    parameter int NUM_MODES = 4,
    parameter int MODE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] load_mode,
    input  logic              adv,
    input  logic [MODE_W-1:0] chk_mode,
    output logic [MODE_W-1:0] pred,
    output logic              hit
);
    localparam logic [MODE_W-1:0] TOP_CODE = MODE_W'(NUM_MODES - 1);

    function automatic logic [MODE_W-1:0] step(input logic [MODE_W-1:0] m);
        return (m == TOP_CODE) ? '0 : m + MODE_W'(1);
    endfunction

    logic [MODE_W-1:0] pred_d, pred_q;

    always_comb begin
        pred_d = pred_q;
        if (load)      pred_d = step(load_mode);
        else if (adv)  pred_d = step(pred_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pred_q <= '0;
        else        pred_q <= pred_d;
    end

    assign pred = pred_q;
    // the last predicted write carried the code just below pred_q
    assign hit  = (step(chk_mode) == pred_q);
endmodule

// File: rtl/pfc_top.sv
module pfc_top #(
    parameter int NUM_MODES = 4,
    parameter int NUM_SLOTS = 6,
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_stb,
    input  logic              det1_vld,
    input  logic [MODE_W-1:0] det1_mode,
    input  logic              det2_vld,
    input  logic [MODE_W-1:0] det2_mode,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [MODE_W-1:0] wr_mode,
    output logic              retry,
    output logic              ce_start
);
    import pfc_pkg::*;

    localparam logic [SLOT_W-1:0] LAST_CAND = SLOT_W'(NUM_MODES - 1);
    localparam logic [SLOT_W-1:0] CAND_CNT  = SLOT_W'(NUM_MODES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    typedef struct packed {
        pfc_state_e        state;
        logic              wr_en;
        logic [SLOT_W-1:0] wr_slot;
        logic [MODE_W-1:0] wr_mode;
        logic              retry;
        logic              start;
    } ctl_t;

    ctl_t r_d, r_q;

    logic              ptr_clr, ptr_inc, ptr_full;
    logic [SLOT_W-1:0] ptr;
    logic              pred_load, pred_adv, pred_hit;
    logic [MODE_W-1:0] pred;
    logic              chk, take;

    pfc_slot_ptr #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ptr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (ptr_clr),
        .inc  (ptr_inc),
        .ptr  (ptr),
        .full (ptr_full)
    );

    pfc_predictor #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pred_load),
        .load_mode(det1_mode),
        .adv      (pred_adv),
        .chk_mode (det2_mode),
        .pred     (pred),
        .hit      (pred_hit)
    );

    always_comb begin
        r_d       = r_q;
        r_d.wr_en = 1'b0;
        r_d.retry = 1'b0;
        r_d.start = 1'b0;
        ptr_clr   = 1'b0;
        ptr_inc   = 1'b0;
        pred_load = 1'b0;
        pred_adv  = 1'b0;
        // verdict needs at least one predicted write already stored
        chk       = det2_vld && (ptr > CAND_CNT);
        take      = sym_stb && !ptr_full;

        case (r_q.state)
            ST_SYM1: begin
                if (sym_stb) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_slot = ptr;
                    r_d.wr_mode = ptr[MODE_W-1:0];
                    ptr_inc     = 1'b1;
                    r_d.state   = (ptr == LAST_CAND) ? ST_WAIT1 : ST_BURST;
                end
            end
            ST_BURST: begin
                r_d.wr_en   = 1'b1;
                r_d.wr_slot = ptr;
                r_d.wr_mode = ptr[MODE_W-1:0];
                ptr_inc     = 1'b1;
                if (ptr == LAST_CAND) r_d.state = ST_WAIT1;
            end
            ST_WAIT1: begin
                if (det1_vld) begin
                    pred_load = 1'b1;
                    r_d.state = ST_PRED;
                end
            end
            ST_PRED: begin
                if (chk && !pred_hit) begin
                    r_d.retry = 1'b1;
                    ptr_clr   = 1'b1;
                    if (sym_stb) begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_slot = '0;
                        r_d.wr_mode = '0;
                        ptr_inc     = 1'b1;
                        r_d.state   = ST_BURST;
                    end else begin
                        r_d.state = ST_SYM1;
                    end
                end else begin
                    if (take) begin
                        r_d.wr_en   = 1'b1;
                        r_d.wr_slot = ptr;
                        r_d.wr_mode = pred;
                        ptr_inc     = 1'b1;
                        pred_adv    = 1'b1;
                    end
                    if (chk) begin
                        if (ptr_full || (take && ptr == LAST_SLOT)) begin
                            r_d.start = 1'b1;
                            r_d.state = ST_DONE;
                        end else begin
                            r_d.state = ST_FILL;
                        end
                    end
                end
            end
            ST_FILL: begin
                if (take) begin
                    r_d.wr_en   = 1'b1;
                    r_d.wr_slot = ptr;
                    r_d.wr_mode = pred;
                    ptr_inc     = 1'b1;
                    pred_adv    = 1'b1;
                    if (ptr == LAST_SLOT) begin
                        r_d.start = 1'b1;
                        r_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
            end
            default: r_d.state = ST_SYM1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_SYM1;
            r_q.wr_en   <= 1'b0;
            r_q.wr_slot <= '0;
            r_q.wr_mode <= '0;
            r_q.retry   <= 1'b0;
            r_q.start   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en    = r_q.wr_en;
    assign wr_slot  = r_q.wr_slot;
    assign wr_mode  = r_q.wr_mode;
    assign retry    = r_q.retry;
    assign ce_start = r_q.start;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
    parameter int NUM_MODES = 4,
    parameter int NUM_SLOTS = 6,
    parameter int MODE_W    = 2,
    parameter int SLOT_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [SLOT_W-1:0] wr_slot,
    input logic [MODE_W-1:0] wr_mode,
    input logic              retry,
    input logic              ce_start
);
    localparam logic [MODE_W-1:0] TOP_CODE = MODE_W'(NUM_MODES - 1);

    logic [SLOT_W-1:0] last_slot_q;
    logic [MODE_W-1:0] last_mode_q;
    logic              done_q, top_wr_q;
    logic [MODE_W-1:0] next_mode;

    assign next_mode = (last_mode_q == TOP_CODE) ? '0 : last_mode_q + MODE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_slot_q <= '0;
            last_mode_q <= '0;
            done_q      <= 1'b0;
            top_wr_q    <= 1'b0;
        end else begin
            if (wr_en) begin
                last_slot_q <= wr_slot;
                last_mode_q <= wr_mode;
            end
            if (ce_start) done_q <= 1'b1;
            if (retry) top_wr_q <= 1'b0;
            else if (wr_en && wr_slot == SLOT_W'(NUM_SLOTS - 1)) top_wr_q <= 1'b1;
        end
    end

    assert_cand_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot < SLOT_W'(NUM_MODES)) |-> (SLOT_W'(wr_mode) == wr_slot));

    assert_slot_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot != '0) |-> (wr_slot == last_slot_q + SLOT_W'(1)));

    assert_pred_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot > SLOT_W'(NUM_MODES)) |-> (wr_mode == next_mode));

    assert_slot_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_slot < SLOT_W'(NUM_SLOTS)));

    assert_start_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ce_start |-> (top_wr_q || (wr_en && wr_slot == SLOT_W'(NUM_SLOTS - 1))));

    assert_retry_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry && wr_en) |-> (wr_slot == '0 && wr_mode == '0));

    assert_retry_not_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> !ce_start);

    assert_quiet_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!wr_en && !retry && !ce_start));
endmodule

bind pfc_top pfc_checker #(
    .NUM_MODES(NUM_MODES),
    .NUM_SLOTS(NUM_SLOTS),
    .MODE_W   (MODE_W),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_mode (wr_mode),
    .retry   (retry),
    .ce_start(ce_start)
);

// File: tb/tb_pfc_top.sv
module tb_pfc_top;
    localparam int NM = 4;
    localparam int NS = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_stb = 1'b0, det1_vld = 1'b0, det2_vld = 1'b0;
    logic [1:0] det1_mode = '0, det2_mode = '0;
    logic       wr_en, retry, ce_start;
    logic [2:0] wr_slot;
    logic [1:0] wr_mode;

    pfc_top #(.NUM_MODES(NM), .NUM_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb),
        .det1_vld(det1_vld), .det1_mode(det1_mode),
        .det2_vld(det2_vld), .det2_mode(det2_mode),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_mode(wr_mode),
        .retry(retry), .ce_start(ce_start)
    );

    initial forever #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0, bad = 0;
    bit log_clr = 1'b1;
    int n_wr, n_rt, n_st, rt_cyc, st_cyc;
    int slot_log [32];
    int mode_log [32];
    int cyc_log  [32];
    int drv_cyc;

    always @(negedge clk) begin
        if (log_clr) begin
            n_wr = 0; n_rt = 0; n_st = 0; rt_cyc = -1; st_cyc = -1;
        end else begin
            if (wr_en && n_wr < 32) begin
                slot_log[n_wr] = int'(wr_slot);
                mode_log[n_wr] = int'(wr_mode);
                cyc_log[n_wr]  = cyc;
                n_wr++;
            end
            if (retry)    begin n_rt++; rt_cyc = cyc; end
            if (ce_start) begin n_st++; st_cyc = cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit s, input bit v1, input int m1, input bit v2, input int m2);
        @(posedge clk); #1;
        sym_stb = s; det1_vld = v1; det1_mode = m1[1:0];
        det2_vld = v2; det2_mode = m2[1:0];
        drv_cyc = cyc;
        @(posedge clk); #1;
        sym_stb = 0; det1_vld = 0; det2_vld = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 0; log_clr = 1;
        idle(3);
        #1 rst_n = 1;
        @(negedge clk); log_clr = 0;
    endtask

    // full sequence with computed expectation
    task automatic run(input int d1, input int np, input int d2);
        int nw, k, d2c, exp_n;
        bit match;
        int es [16];
        int em [16];
        do_reset();
        step(1, 0, 0, 0, 0); idle(6);
        step(0, 1, d1, 0, 0);
        for (int i = 0; i < np; i++) begin step(1, 0, 0, 0, 0); idle(3); end
        step(0, 0, 0, 1, d2); d2c = drv_cyc;
        for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, 0); idle(6); end
        idle(2);
        nw = (np < NS - NM) ? np : NS - NM;
        match = (d2 == (d1 + nw) % NM);
        k = 0;
        for (int i = 0; i < NM; i++) begin es[k] = i; em[k] = i; k++; end
        for (int i = 0; i < nw; i++) begin es[k] = NM + i; em[k] = (d1 + 1 + i) % NM; k++; end
        if (match) begin
            for (int i = NM + nw; i < NS; i++) begin es[k] = i; em[k] = (d1 + 1 + (i - NM)) % NM; k++; end
        end else begin
            for (int i = 0; i < NM; i++) begin es[k] = i; em[k] = i; k++; end
        end
        exp_n = k;
        check(n_wr == exp_n, (np > 2) ? "R4 write count" : "R3 write count", n_wr, exp_n);
        for (int i = 0; i < exp_n && i < n_wr; i++) begin
            check(slot_log[i] == es[i], (i < NM) ? "R1 slot" : "R3 slot", slot_log[i], es[i]);
            check(mode_log[i] == em[i], (i < NM) ? "R1 code" : ((i == NM) ? "R2 code" : "R3 code"),
                  mode_log[i], em[i]);
        end
        if (n_wr >= NM) check(cyc_log[NM-1] == cyc_log[0] + NM - 1, "R1 consecutive",
                              cyc_log[NM-1] - cyc_log[0], NM - 1);
        if (match) begin
            check(n_st == 1 && n_rt == 0, "R6 start once, no retry", n_st * 10 + n_rt, 10);
            if (nw < NS - NM) check(st_cyc == cyc_log[NS-1], "R6 start with last write", st_cyc, cyc_log[NS-1]);
            else              check(st_cyc == d2c + 1, "R6 start after decision", st_cyc, d2c + 1);
        end else begin
            check(n_rt == 1 && n_st == 0, "R7 retry once, no start", n_rt * 10 + n_st, 10);
            check(rt_cyc == d2c + 1, "R7 retry timing", rt_cyc, d2c + 1);
        end
    endtask

    initial begin
        int base;
        rst_n = 0;
        idle(2);
        @(negedge clk);
        check(!wr_en && !retry && !ce_start, "R10 reset outputs", {wr_en, retry, ce_start}, 0);
        do_reset();
        check(!wr_en && !retry && !ce_start, "R10 after reset", {wr_en, retry, ce_start}, 0);

        // sweep
        for (int d1 = 0; d1 < NM; d1++)
            for (int np = 1; np <= 3; np++)
                for (int d2 = 0; d2 < NM; d2++)
                    run(d1, np, d2);

        // decisions at ignored moments
        do_reset();
        step(1, 0, 0, 0, 0);
        step(0, 1, 2, 1, 0);           // inside candidate writes: ignored
        idle(4);
        step(0, 0, 0, 1, 0);           // no prediction yet: ignored
        step(0, 1, 1, 0, 0);           // prediction becomes 2
        step(0, 0, 0, 1, 3);           // no predicted write yet: ignored
        step(1, 0, 0, 0, 0); idle(3);
        check(n_wr == 5, "R2 writes after ignored decisions", n_wr, 5);
        check(mode_log[4] == 2, "R2 decision during burst ignored", mode_log[4], 2);
        check(n_rt == 0 && n_st == 0, "R5 early second decision ignored", n_rt + n_st, 0);
        step(0, 0, 0, 1, 2);
        step(1, 0, 0, 0, 0); idle(3);
        check(n_wr == 6 && mode_log[5] == 3, "R6 fill after match", mode_log[5], 3);
        check(n_st == 1, "R6 start", n_st, 1);
        step(1, 0, 0, 0, 0); step(0, 1, 0, 1, 0); idle(3);
        check(n_wr == 6 && n_st == 1 && n_rt == 0, "R9 quiet after start", n_wr, 6);

        // same-cycle mismatch
        do_reset();
        step(1, 0, 0, 0, 0); idle(6);
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0); idle(3);
        step(1, 0, 0, 1, 3); base = drv_cyc; idle(8);
        check(n_wr == 9, "R8 mismatch write count", n_wr, 9);
        check(slot_log[5] == 0 && mode_log[5] == 0, "R8 restart slot", slot_log[5], 0);
        check(cyc_log[5] == base + 1 && rt_cyc == base + 1, "R8 retry with restart write", rt_cyc, base + 1);
        // second round after restart
        step(0, 1, 3, 0, 0);
        step(1, 0, 0, 0, 0); idle(3);
        check(slot_log[9] == 4 && mode_log[9] == 0, "R7 new round prediction", mode_log[9], 0);
        step(0, 0, 0, 1, 0);
        step(1, 0, 0, 0, 0); idle(3);
        check(slot_log[10] == 5 && mode_log[10] == 1 && n_st == 1, "R7 second round start",
              mode_log[10], 1);

        // same-cycle match
        do_reset();
        step(1, 0, 0, 0, 0); idle(6);
        step(0, 1, 0, 0, 0);
        step(1, 0, 0, 0, 0); idle(3);
        step(1, 0, 0, 1, 1); base = drv_cyc; idle(4);
        check(n_wr == 6 && slot_log[5] == 5 && mode_log[5] == 2, "R8 match fill write", mode_log[5], 2);
        check(n_st == 1 && st_cyc == base + 1 && n_rt == 0, "R8 start same cycle", st_cyc, base + 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(200000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule